// File: doc/BRIEF.md
# Parameterized Funnel Shifter

This block is a purely combinational shift and rotate unit for a datapath. It takes an operand of `WIDTH` bits, a shift amount, a direction bit and a two-bit kind code. It returns the operand shifted or rotated by that amount. It supports logical, arithmetic and rotate kinds, each in both directions.

There is no separate left shifter or right shifter. The block first forms a word of 2·WIDTH−1 bits. That word holds the operand and, depending on kind and direction, a fill of zeros, sign copies or the operand's own bits. A chain of log2(WIDTH) two-input multiplexer stages then picks a WIDTH-bit window out of it. Each stage is steered directly by one bit of the window offset, so no select decoding is needed. For a right shift the offset is the amount itself. For a left shift the offset is the bitwise complement of the amount.

Top module: `funnel_shifter`

## Requirements
- R1: With kind 00 (logical) and direction right (left_i=0), y_o equals a_i shifted toward bit 0 by amt_i, and the amt_i top bits are zero.
- R2: With kind 01 (arithmetic) and direction right, y_o equals a_i shifted toward bit 0 by amt_i, and the vacated top bits are copies of a_i[WIDTH-1].
- R3: With kind 10 (rotate) and direction right, y_o[i] equals a_i[(i+amt_i) mod WIDTH].
- R4: With kind 00 and direction left (left_i=1), y_o equals a_i shifted toward the top bit by amt_i, and the amt_i low bits are zero.
- R5: With kind 01 and direction left, y_o equals the logical left shift of a_i (zero fill, no sign copy).
- R6: With kind 10 and direction left, y_o[i] equals a_i[(i−amt_i) mod WIDTH].
- R7: With amt_i equal to zero, y_o equals a_i for every kind and direction.
- R8: Kind code 11 is reserved and gives exactly the logical result for the same direction and amount.
- R9: The behaviour of R1 to R8 holds for any power-of-two WIDTH of at least 2; other widths are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand to shift or rotate |
| amt_i | input | $clog2(WIDTH) | Shift amount, 0 to WIDTH−1 |
| left_i | input | 1 | 1 = toward the top bit, 0 = toward bit 0 |
| kind_i | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 reserved (logical) |
| y_o | output | WIDTH | Shifted or rotated result |

## Verification
The bench builds two instances, one with WIDTH=8 and one with WIDTH=4. With both widths it can sweep every operand value, every amount, both directions and all four kind codes, reserved code included. That is 16384 vectors for the wide instance and 512 for the narrow one. Every window offset and every fill pattern is therefore reached, including the edge amounts 0 and WIDTH−1 and operands with the sign bit set and clear. The four-bit instance also covers the small worked cases, such as 1011 shifted or rotated by one in each direction. It also shows that the multiplexer chain is correct at a depth of two stages as well as three.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
   typedef enum logic [1:0] {
      KIND_LOGIC  = 2'b00,
      KIND_ARITH  = 2'b01,
      KIND_ROTATE = 2'b10,
      KIND_RSVD   = 2'b11
   } shift_kind_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/fsh_concat_build.sv
module fsh_concat_build
   import fsh_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int CAT_W = 2 * WIDTH - 1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic             left_i,
   input  logic [1:0]       kind_i,
   output logic [CAT_W-1:0] cat_o
);
   logic [WIDTH-2:0] hi_fill;
   logic [WIDTH-2:0] lo_fill;

   // Fill placed above the operand for right moves.
   always_comb begin
      unique case (shift_kind_e'(kind_i))
         KIND_ARITH:  hi_fill = {(WIDTH-1){a_i[WIDTH-1]}};
         KIND_ROTATE: hi_fill = a_i[WIDTH-2:0];
         default:     hi_fill = '0;
      endcase
   end

   // Fill placed below the operand for left moves.
   always_comb begin
      if (shift_kind_e'(kind_i) == KIND_ROTATE) lo_fill = a_i[WIDTH-1:1];
      else                                      lo_fill = '0;
   end

   always_comb begin
      if (left_i) cat_o = {a_i, lo_fill};
      else        cat_o = {hi_fill, a_i};
   end

   // Right moves keep the operand in the low field.
   always_comb begin
      if (!left_i) a_r2_operand_low: assert (cat_o[WIDTH-1:0] == a_i)
         else $error("right move lost operand in low field");
      if (left_i)  a_r4_operand_high: assert (cat_o[CAT_W-1:WIDTH-1] == a_i)
         else $error("left move lost operand in high field");
   end
endmodule

// File: rtl/fsh_offset_ctrl.sv
module fsh_offset_ctrl #(
   parameter int WIDTH = 8,
   localparam int AMT_W = $clog2(WIDTH)
) (
   input  logic [AMT_W-1:0] amt_i,
   input  logic             left_i,
   output logic [AMT_W-1:0] off_o
);
   // Window base: amount for right, (WIDTH-1-amount) for left, which
   // is the bitwise complement since WIDTH is a power of two.
   always_comb off_o = left_i ? ~amt_i : amt_i;

   always_comb begin
      a_r9_offset_sum: assert (!left_i || (int'(off_o) + int'(amt_i) == WIDTH - 1))
         else $error("left offset does not equal WIDTH-1-amount");
   end
endmodule

// File: rtl/fsh_mux_stage.sv
module fsh_mux_stage #(
   parameter int IN_W = 15,
   parameter int STEP = 4,
   localparam int OUT_W = IN_W - STEP
) (
   input  logic [IN_W-1:0]  in_i,
   input  logic             sel_i,
   output logic [OUT_W-1:0] out_o
);
   if (STEP < 1 || OUT_W < 1) begin : g_bad
      $error("fsh_mux_stage: illegal STEP/IN_W");
   end

   always_comb begin
      for (int j = 0; j < OUT_W; j++) begin
         out_o[j] = sel_i ? in_i[j + STEP] : in_i[j];
      end
   end
endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
   import fsh_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int AMT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic             left_i,
   input  logic [1:0]       kind_i,
   output logic [WIDTH-1:0] y_o
);
   localparam int CAT_W = 2 * WIDTH - 1;

   if (!is_pow2(WIDTH)) begin : g_width_chk
      $error("funnel_shifter: WIDTH must be a power of two >= 2");
   end

   logic [CAT_W-1:0] cat;
   logic [AMT_W-1:0] off;

   fsh_concat_build #(.WIDTH(WIDTH)) u_cat (
      .a_i    (a_i),
      .left_i (left_i),
      .kind_i (kind_i),
      .cat_o  (cat)
   );

   fsh_offset_ctrl #(.WIDTH(WIDTH)) u_off (
      .amt_i  (amt_i),
      .left_i (left_i),
      .off_o  (off)
   );

   // Stage b moves the window by 2**b; widest stage first.
   for (genvar b = AMT_W - 1; b >= 0; b--) begin : g_st
      localparam int IN_W  = WIDTH - 1 + (2 << b);
      localparam int OUT_W = WIDTH - 1 + (1 << b);
      logic [IN_W-1:0]  w_in;
      logic [OUT_W-1:0] w_out;
      if (b == AMT_W - 1) begin : g_first
         assign w_in = cat;
      end else begin : g_next
         assign w_in = g_st[b+1].w_out;
      end
      fsh_mux_stage #(.IN_W(IN_W), .STEP(1 << b)) u_stage (
         .in_i  (w_in),
         .sel_i (off[b]),
         .out_o (w_out)
      );
   end

   assign y_o = g_st[0].w_out;

   // Result checks against the operand and control inputs.
   logic [WIDTH-1:0] low_part;
   logic [WIDTH-1:0] high_part;
   always_comb begin
      low_part  = y_o << (WIDTH - int'(amt_i));
      high_part = y_o >> (WIDTH - int'(amt_i));
   end

   always_comb begin
      if (amt_i == '0)
         a_r7_zero_amount: assert (y_o == a_i)
            else $error("zero amount changed operand");
      if (!left_i && (kind_i == 2'b00 || kind_i == 2'b11))
         a_r1_zero_fill_top: assert (high_part == '0)
            else $error("logical right fill not zero");
      if (!left_i && kind_i == 2'b01)
         a_r2_sign_kept: assert (y_o[WIDTH-1] == a_i[WIDTH-1])
            else $error("arithmetic right lost sign");
      if (left_i && kind_i != 2'b10)
         a_r5_zero_fill_low: assert (low_part == '0)
            else $error("left shift low fill not zero");
      if (kind_i == 2'b10)
         a_r6_rotate_ones: assert ($countones(y_o) == $countones(a_i))
            else $error("rotate changed population count");
   end
endmodule

// File: tb/funnel_shifter_tb.sv
module funnel_shifter_tb;
   logic clk = 1'b0;
   logic rst_n;
   always #10 clk = ~clk;

   logic [7:0] a8, y8;
   logic [2:0] k8;
   logic [3:0] a4, y4;
   logic [1:0] k4;
   logic       left;
   logic [1:0] kind;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   funnel_shifter #(.WIDTH(8)) u_dut (
      .a_i(a8), .amt_i(k8), .left_i(left), .kind_i(kind), .y_o(y8));

   funnel_shifter #(.WIDTH(4)) u_dut4 (
      .a_i(a4), .amt_i(k4), .left_i(left), .kind_i(kind), .y_o(y4));

   // Bitwise behavioural model from the requirement text.
   function automatic logic [7:0] model(int w, logic [7:0] a, int k, bit lft, int kd);
      logic [7:0] r = '0;
      for (int i = 0; i < w; i++) begin
         int src;
         if (lft) begin
            src = i - k;
            if (src >= 0)    r[i] = a[src];
            else if (kd == 2) r[i] = a[src + w];
            else             r[i] = 1'b0;
         end else begin
            src = i + k;
            if (src < w)     r[i] = a[src];
            else if (kd == 2) r[i] = a[src - w];
            else if (kd == 1) r[i] = a[w - 1];
            else             r[i] = 1'b0;
         end
      end
      return r;
   endfunction

   function automatic string tag_of(int w, int k, bit lft, int kd);
      string t;
      if (k == 0)       t = "R7";
      else if (kd == 3) t = "R8";
      else if (!lft)    t = (kd == 0) ? "R1" : (kd == 1) ? "R2" : "R3";
      else              t = (kd == 0) ? "R4" : (kd == 1) ? "R5" : "R6";
      if (w == 4) t = {t, "/R9"};
      return t;
   endfunction

   task automatic check(string tag, int act, int exp, string ctx);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, ctx, act, exp);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      a8 = '0; k8 = '0; a4 = '0; k4 = '0; left = 1'b0; kind = 2'b00;
      repeat (3) @(posedge clk);
      @(negedge clk); #5;
      check("R7", int'(y8), 0, "reset state w8");
      check("R7", int'(y4), 0, "reset state w4");
      rst_n = 1'b1;

      // Exhaustive sweep, WIDTH=8 (R1..R8).
      for (int kd = 0; kd < 4; kd++)
         for (int d = 0; d < 2; d++)
            for (int k = 0; k < 8; k++)
               for (int a = 0; a < 256; a++) begin
                  @(negedge clk);
                  a8 = a[7:0]; k8 = k[2:0]; left = d[0]; kind = kd[1:0];
                  #5;
                  check(tag_of(8, k, d[0], kd), int'(y8),
                        int'(model(8, a[7:0], k, d[0], kd)),
                        $sformatf("w8 a=%02h k=%0d left=%0d kind=%0d", a, k, d, kd));
               end

      // Exhaustive sweep, WIDTH=4 (R9 plus R1..R8).
      for (int kd = 0; kd < 4; kd++)
         for (int d = 0; d < 2; d++)
            for (int k = 0; k < 4; k++)
               for (int a = 0; a < 16; a++) begin
                  @(negedge clk);
                  a4 = a[3:0]; k4 = k[1:0]; left = d[0]; kind = kd[1:0];
                  #5;
                  check(tag_of(4, k, d[0], kd), int'(y4),
                        int'(model(4, {4'b0, a[3:0]}, k, d[0], kd)),
                        $sformatf("w4 a=%0h k=%0d left=%0d kind=%0d", a, k, d, kd));
               end

      // Worked 4-bit cases on 1011 by one.
      a4 = 4'b1011; k4 = 2'd1;
      left = 1'b0; kind = 2'b00; #5; check("R1", int'(y4), 4'b0101, "1011 logical right");
      left = 1'b1; kind = 2'b00; #5; check("R4", int'(y4), 4'b0110, "1011 logical left");
      left = 1'b0; kind = 2'b01; #5; check("R2", int'(y4), 4'b1101, "1011 arith right");
      left = 1'b1; kind = 2'b01; #5; check("R5", int'(y4), 4'b0110, "1011 arith left");
      left = 1'b0; kind = 2'b10; #5; check("R3", int'(y4), 4'b1101, "1011 rotate right");
      left = 1'b1; kind = 2'b10; #5; check("R6", int'(y4), 4'b0111, "1011 rotate left");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule